// File: doc/BRIEF.md
# Two-Stage Region Protection Checker

This block decides whether a memory access by a real-time core may proceed. The core runs at one of three privilege levels: EL0 for applications, EL1 for a guest kernel and EL2 for the hypervisor. Every request carries an address, an access kind (read, write or instruction fetch) and the level that issued it. The block answers one cycle later with permit or fault. On a fault it also says which stage refused the access and which region was involved.

Two region tables hold the rules. The guest table sets the rules a guest kernel lays down for itself and its applications. The hypervisor table has two roles. For EL2 accesses it is the only check (stage 1). For EL1 and EL0 accesses it is a second check (stage 2), which runs only after the guest table has accepted the access. A guest can therefore never reach memory that the hypervisor has not granted. Addresses pass through unchanged; the block does not translate them.

Regions are written through a single write port, one whole region per write. The same port also sets the background-enable bit of either table.

Top module: `mpu2_check`

## Requirements
- R1: After reset, every region of both tables is disabled, both background bits are clear and `rsp_valid` is 0. Any access then faults in stage 1 with region code NOMATCH, which is all ones on `rsp_region` (31 with the default parameters).
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. The result shown belongs to that request.
- R3: A region matches an address when the region is enabled and base ≤ address ≤ limit, comparing only address bits [ADDR_W-1:6]. Address bits [5:0] of the base, limit and request are ignored. A disabled region never matches.
- R4: When several regions of one table match, the region with the lowest index alone decides the outcome for that table.
- R5: `cfg_attr` bit 1 marks a region read-only: a write (`req_type` = 1) to it faults. Bit 2 marks it no-execute: a fetch (`req_type` = 2) from it faults. Reads (`req_type` 0 or 3) are refused by neither bit.
- R6: `cfg_attr` bit 3 grants EL0 access. An EL0 access (`req_el` = 0) to a region in either table that lacks this bit faults. EL1 and EL2 accesses ignore the bit. Bit 0 enables the region.
- R7: An access that matches no region in a table it must pass is permitted by that table only if the table's background bit is set and the access is not from EL0. An EL0 access that matches nothing always faults.
- R8: An EL2 access (`req_el` 2 or 3) is checked only by the hypervisor table, as stage 1. The guest table has no effect on it, and it never reports a stage-2 fault.
- R9: For an EL1 or EL0 access refused by the guest table, the response shows a fault, `rsp_stage2` = 0 and the guest region index (or NOMATCH). The hypervisor table does not change this result.
- R10: An EL1 or EL0 access accepted by the guest table is then checked by the hypervisor table. A refusal there shows a fault, `rsp_stage2` = 1 and the hypervisor region index (or NOMATCH).
- R11: On a permit, `rsp_fault` and `rsp_stage2` are 0. `rsp_region` holds the index of the hypervisor-table region that decided the last stage, or NOMATCH when a background bit granted it.
- R12: A write with `cfg_bg` = 0 stores base, limit and attributes into region `cfg_idx` of the table picked by `cfg_hyp` (1 = hypervisor, 0 = guest); an index ≥ NREG is ignored. A write with `cfg_bg` = 1 sets that table's background bit from `cfg_attr` bit 0. A write affects requests in later cycles only, not a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_hyp | input | 1 | Table select: 1 hypervisor, 0 guest |
| cfg_bg | input | 1 | 1: write background bit; 0: write a region |
| cfg_idx | input | RIDX_W | Region index to write |
| cfg_base | input | ADDR_W | Region base address (bits [5:0] ignored) |
| cfg_limit | input | ADDR_W | Region inclusive limit address (bits [5:0] ignored) |
| cfg_attr | input | 4 | {EL0 grant, no-execute, read-only, enable}; bit 0 is the background value when cfg_bg=1 |
| req_valid | input | 1 | Access request present |
| req_el | input | 2 | Issuing level: 0 EL0, 1 EL1, 2 or 3 EL2 |
| req_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_addr | input | ADDR_W | Access address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_fault | output | 1 | Access refused |
| rsp_stage2 | output | 1 | Fault raised by stage 2 |
| rsp_region | output | RIDX_W | Deciding region index, or NOMATCH (all ones) |

## Verification
A wrong entry in either table shows up at the ports as a changed permit, fault, stage or index, but only for requests whose address falls inside the affected range. The bench therefore keeps its own copy of both tables and checks every response against it, one cycle after each request. Random addresses are drawn inside the programmed ranges so that corrupted bounds, attributes or priority are found within a few dozen requests. A wrong background bit shows only for addresses that no region covers, so the random mix always includes such addresses.

// File: rtl/mpu2_pkg.sv
`timescale 1ns/1ps
// Shared types for the two-stage region protection checker.
// Assumes: attribute bit order is fixed by the write port (bit 0 enable).
package mpu2_pkg;

    // Region attribute bits, MSB first: EL0 grant, no-execute, read-only, enable
    typedef struct packed {
        logic el0ok;
        logic xn;
        logic ro;
        logic en;
    } rgn_attr_t;

    // Access kind codes carried on req_type
    localparam logic [1:0] ACC_WR = 2'd1;
    localparam logic [1:0] ACC_EX = 2'd2;

endpackage

// File: rtl/mpu2_rgn_table.sv
`timescale 1ns/1ps
// One region table: NREG regions of 64-byte granules plus a background bit.
// Looks up one address per cycle combinationally; the lowest matching index wins.
// Assumes: NREG < 2**RIDX_W so the all-ones index is free as the no-match code.
module mpu2_rgn_table
    import mpu2_pkg::*;
#(
    parameter int GW     = 26,
    parameter int NREG   = 24,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_bg,
    input  logic [RIDX_W-1:0] wr_idx,
    input  logic [GW-1:0]     wr_base,
    input  logic [GW-1:0]     wr_limit,
    input  rgn_attr_t         wr_attr,
    input  logic [GW-1:0]     lk_gran,
    output logic              hit,
    output logic [RIDX_W-1:0] hit_idx,
    output rgn_attr_t         hit_attr,
    output logic              bg_en
);
    localparam logic [RIDX_W-1:0] NOMATCH = '1;

    logic [NREG-1:0] match;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_rgn
        logic [GW-1:0] base_q;
        logic [GW-1:0] limit_q;
        rgn_attr_t     attr_q;

        // Store one region when the write port addresses it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q  <= '0;
                limit_q <= '0;
                attr_q  <= '0;
            end else if (wr_en && !wr_bg && wr_idx == RIDX_W'(gi)) begin
                base_q  <= wr_base;
                limit_q <= wr_limit;
                attr_q  <= wr_attr;
            end
        end

        // Inclusive granule range compare for this region
        assign match[gi] = attr_q.en && (lk_gran >= base_q) && (lk_gran <= limit_q);
    end

    // Background (default map) enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            bg_en <= 1'b0;
        else if (wr_en && wr_bg)
            bg_en <= wr_attr.en;
    end

    // Priority select: scan downward so the lowest index is assigned last
    always_comb begin
        hit      = 1'b0;
        hit_idx  = NOMATCH;
        hit_attr = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_idx  = RIDX_W'(i);
                hit_attr = g_attr_mux(i);
            end
        end
    end

    // Attribute read of region k (generate scopes need a function to index)
    function automatic rgn_attr_t g_attr_mux(input int k);
        rgn_attr_t a;
        a = '0;
        for (int j = 0; j < NREG; j++)
            if (j == k) a = attr_of(j);
        return a;
    endfunction

    rgn_attr_t attr_vec [NREG];
    for (genvar gj = 0; gj < NREG; gj++) begin : g_attr_out
        assign attr_vec[gj] = g_rgn[gj].attr_q;
    end

    function automatic rgn_attr_t attr_of(input int k);
        return attr_vec[k];
    endfunction

    // Encoder output must agree with the match vector it came from
    always_comb begin
        if (rst_n && hit) begin
            // R3
            hit_match_chk: assert (match[hit_idx])
                else $error("winner index does not match");
            // R4
            win_lowest_chk: assert ((match & ((NREG'(1) << hit_idx) - NREG'(1))) == '0)
                else $error("lower-numbered region also matched");
        end
    end

endmodule

// File: rtl/mpu2_perm.sv
`timescale 1ns/1ps
// Permission decision of one table for one access.
// Assumes: attr is meaningful only when hit is set.
module mpu2_perm
    import mpu2_pkg::*;
(
    input  logic      hit,
    input  rgn_attr_t attr,
    input  logic      bg_en,
    input  logic      el0,
    input  logic      is_wr,
    input  logic      is_ex,
    output logic      ok
);
    // Region rules when matched, background rule otherwise
    always_comb begin
        if (hit)
            ok = attr.en && !(is_wr && attr.ro) && !(is_ex && attr.xn) && !(el0 && !attr.el0ok);
        else
            ok = bg_en && !el0;
    end
endmodule

// File: rtl/mpu2_check.sv
`timescale 1ns/1ps
// Two-stage region protection checker, top level.
// EL2 accesses: hypervisor table only (stage 1). EL1/EL0: guest table (stage 1),
// then hypervisor table (stage 2). Both tables are looked up in parallel; the
// result is registered, one cycle from request to response.
// Assumes: identity addressing; NREG < 2**RIDX_W.
module mpu2_check
    import mpu2_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NREG   = 24,
    parameter int RIDX_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_hyp,
    input  logic              cfg_bg,
    input  logic [RIDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_limit,
    input  logic [3:0]        cfg_attr,
    input  logic              req_valid,
    input  logic [1:0]        req_el,
    input  logic [1:0]        req_type,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic              rsp_stage2,
    output logic [RIDX_W-1:0] rsp_region
);
    localparam int GW = ADDR_W - 6;

    logic unused_low;
    assign unused_low = ^{req_addr[5:0], cfg_base[5:0], cfg_limit[5:0]};

    // Request decode
    logic el2, el0, is_wr, is_ex;
    assign el2   = req_el[1];
    assign el0   = (req_el == 2'd0);
    assign is_wr = (req_type == ACC_WR);
    assign is_ex = (req_type == ACC_EX);

    rgn_attr_t         wattr;
    assign wattr = rgn_attr_t'(cfg_attr);

    logic              g_hit, h_hit, g_bg, h_bg, g_ok, h_ok;
    logic [RIDX_W-1:0] g_idx, h_idx;
    rgn_attr_t         g_attr, h_attr;

    mpu2_rgn_table #(.GW(GW), .NREG(NREG), .RIDX_W(RIDX_W)) u_gtab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && !cfg_hyp), .wr_bg(cfg_bg), .wr_idx(cfg_idx),
        .wr_base(cfg_base[ADDR_W-1:6]), .wr_limit(cfg_limit[ADDR_W-1:6]), .wr_attr(wattr),
        .lk_gran(req_addr[ADDR_W-1:6]),
        .hit(g_hit), .hit_idx(g_idx), .hit_attr(g_attr), .bg_en(g_bg)
    );

    mpu2_rgn_table #(.GW(GW), .NREG(NREG), .RIDX_W(RIDX_W)) u_htab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we && cfg_hyp), .wr_bg(cfg_bg), .wr_idx(cfg_idx),
        .wr_base(cfg_base[ADDR_W-1:6]), .wr_limit(cfg_limit[ADDR_W-1:6]), .wr_attr(wattr),
        .lk_gran(req_addr[ADDR_W-1:6]),
        .hit(h_hit), .hit_idx(h_idx), .hit_attr(h_attr), .bg_en(h_bg)
    );

    mpu2_perm u_gperm (
        .hit(g_hit), .attr(g_attr), .bg_en(g_bg),
        .el0(el0), .is_wr(is_wr), .is_ex(is_ex), .ok(g_ok)
    );

    mpu2_perm u_hperm (
        .hit(h_hit), .attr(h_attr), .bg_en(h_bg),
        .el0(el0), .is_wr(is_wr), .is_ex(is_ex), .ok(h_ok)
    );

    // Combine stages: EL2 sees only the hypervisor table; guests need both
    logic              n_fault, n_s2;
    logic [RIDX_W-1:0] n_idx;
    always_comb begin
        if (el2) begin
            n_fault = !h_ok;
            n_s2    = 1'b0;
            n_idx   = h_idx;
        end else if (!g_ok) begin
            n_fault = 1'b1;
            n_s2    = 1'b0;
            n_idx   = g_idx;
        end else begin
            n_fault = !h_ok;
            n_s2    = !h_ok;
            n_idx   = h_idx;
        end
    end

    // Response register: one cycle of latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_stage2 <= 1'b0;
            rsp_region <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault  <= n_fault;
                rsp_stage2 <= n_s2;
                rsp_region <= n_idx;
            end
        end
    end

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R8
    el2_no_s2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_el[1] |=> !rsp_stage2);
    // R7
    el0_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_el == 2'd0 && !g_hit |=> rsp_fault && !rsp_stage2);

endmodule

// File: tb/mpu2_check_tb.sv
`timescale 1ns/1ps
// Bench: directed corners then seeded random traffic against a reference model.
module mpu2_check_tb;
    localparam int ADDR_W = 32;
    localparam int NREG   = 24;
    localparam int RIDX_W = 5;
    localparam int NOM    = 31;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 0, cfg_hyp = 0, cfg_bg = 0;
    logic [RIDX_W-1:0] cfg_idx = '0;
    logic [ADDR_W-1:0] cfg_base = '0, cfg_limit = '0;
    logic [3:0]        cfg_attr = '0;
    logic              req_valid = 0;
    logic [1:0]        req_el = '0, req_type = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid, rsp_fault, rsp_stage2;
    logic [RIDX_W-1:0] rsp_region;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mpu2_check #(.ADDR_W(ADDR_W), .NREG(NREG), .RIDX_W(RIDX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_hyp(cfg_hyp), .cfg_bg(cfg_bg),
        .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_attr(cfg_attr),
        .req_valid(req_valid), .req_el(req_el), .req_type(req_type), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_stage2(rsp_stage2),
        .rsp_region(rsp_region)
    );

    // Reference tables: [0] guest, [1] hypervisor
    logic [31:0] m_base [2][NREG];
    logic [31:0] m_lim  [2][NREG];
    logic [3:0]  m_attr [2][NREG];
    bit          m_bg   [2];

    function automatic void m_reset();
        for (int t = 0; t < 2; t++) begin
            m_bg[t] = 0;
            for (int i = 0; i < NREG; i++) begin
                m_base[t][i] = 0; m_lim[t][i] = 0; m_attr[t][i] = 0;
            end
        end
    endfunction

    // One table's verdict per requirements R3..R7
    function automatic void m_table(input int t, input logic [31:0] a, input logic [1:0] el,
                                    input logic [1:0] ty, output bit ok, output int idx);
        idx = NOM;
        for (int i = 0; i < NREG; i++)
            if (idx == NOM && m_attr[t][i][0] &&
                a[31:6] >= m_base[t][i][31:6] && a[31:6] <= m_lim[t][i][31:6])
                idx = i;
        if (idx == NOM)
            ok = m_bg[t] && (el != 0);
        else
            ok = !(ty == 1 && m_attr[t][idx][1]) && !(ty == 2 && m_attr[t][idx][2]) &&
                 !(el == 0 && !m_attr[t][idx][3]);
    endfunction

    function automatic void m_expect(input logic [31:0] a, input logic [1:0] el, input logic [1:0] ty,
                                     output bit f, output bit s2, output int idx);
        bit gok, hok; int gi, hi;
        m_table(0, a, el, ty, gok, gi);
        m_table(1, a, el, ty, hok, hi);
        if (el[1]) begin f = !hok; s2 = 0; idx = hi; end
        else if (!gok) begin f = 1; s2 = 0; idx = gi; end
        else begin f = !hok; s2 = !hok; idx = hi; end
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Model update for a write (called when the write edge is committed)
    function automatic void m_write(input bit hyp, input bit bg, input int idx,
                                    input logic [31:0] b, input logic [31:0] l, input logic [3:0] at);
        if (bg) m_bg[hyp] = at[0];
        else if (idx < NREG) begin
            m_base[hyp][idx] = b; m_lim[hyp][idx] = l; m_attr[hyp][idx] = at;
        end
    endfunction

    task automatic cfg_write(input bit hyp, input bit bg, input int idx,
                             input logic [31:0] b, input logic [31:0] l, input logic [3:0] at);
        cfg_we = 1; cfg_hyp = hyp; cfg_bg = bg; cfg_idx = RIDX_W'(idx);
        cfg_base = b; cfg_limit = l; cfg_attr = at;
        @(negedge clk);
        cfg_we = 0;
        m_write(hyp, bg, idx, b, l, at);
    endtask

    // Directed access with hand-computed expectation
    task automatic access(input string tag, input logic [1:0] el, input logic [1:0] ty,
                          input logic [31:0] a, input bit ef, input bit es, input int ei);
        req_valid = 1; req_el = el; req_type = ty; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        chk({tag, " valid"}, {31'd0, rsp_valid}, 1);
        chk({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, ef});
        chk({tag, " stage2"}, {31'd0, rsp_stage2}, {31'd0, es});
        chk({tag, " region"}, {27'd0, rsp_region}, ei);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit f, s2; int ei;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid idle", {31'd0, rsp_valid}, 0);
        access("R1 EL1 read empty", 2'd1, 2'd0, 32'h100, 1, 0, NOM);
        access("R1 EL2 read empty", 2'd2, 2'd0, 32'h100, 1, 0, NOM);
        // R2 valid drops when no request
        @(negedge clk);
        chk("R2 valid drops", {31'd0, rsp_valid}, 0);

        cfg_write(0, 0, 0, 32'h1000, 32'h1FC0, 4'b1001);
        cfg_write(1, 0, 0, 32'h1000, 32'h1000, 4'b1011);
        cfg_write(1, 0, 1, 32'h0,    32'hFFC0, 4'b1001);
        // R3 inclusive bounds, low bits ignored
        access("R3 top of limit granule", 2'd0, 2'd0, 32'h1FFF, 0, 0, 1);
        access("R3 past limit", 2'd0, 2'd0, 32'h2000, 1, 0, NOM);
        access("R3 below base", 2'd0, 2'd0, 32'h0FFF, 1, 0, NOM);
        // R4 lowest index wins
        cfg_write(0, 0, 1, 32'h1000, 32'h10C0, 4'b0011);
        access("R4 region0 beats ro region1", 2'd1, 2'd1, 32'h1080, 0, 0, 1);
        cfg_write(0, 0, 2, 32'h3000, 32'h3000, 4'b0011);
        cfg_write(0, 0, 3, 32'h3000, 32'h3000, 4'b1001);
        access("R4 ro region2 beats region3 (R9)", 2'd1, 2'd1, 32'h3010, 1, 0, 2);
        // R5 read-only and no-execute
        access("R5 read of ro", 2'd1, 2'd0, 32'h3010, 0, 0, 1);
        access("R5 read code3 of ro", 2'd1, 2'd3, 32'h3010, 0, 0, 1);
        cfg_write(0, 0, 4, 32'h4000, 32'h4000, 4'b0101);
        access("R5 fetch from xn", 2'd1, 2'd2, 32'h4000, 1, 0, 4);
        access("R5 read from xn", 2'd1, 2'd0, 32'h4000, 0, 0, 1);
        // R6 EL0 grant
        cfg_write(0, 0, 5, 32'h5000, 32'h5000, 4'b0001);
        access("R6 EL0 without grant", 2'd0, 2'd0, 32'h5000, 1, 0, 5);
        access("R6 EL1 ignores grant", 2'd1, 2'd0, 32'h5000, 0, 0, 1);
        // R7 background
        access("R7 EL1 no match bg off", 2'd1, 2'd0, 32'h8000, 1, 0, NOM);
        cfg_write(0, 1, 0, 0, 0, 4'b0001);
        access("R7 EL1 guest bg", 2'd1, 2'd0, 32'h8000, 0, 0, 1);
        access("R7 EL0 never bg", 2'd0, 2'd0, 32'h8000, 1, 0, NOM);
        access("R10 stage2 no match", 2'd1, 2'd0, 32'h20000, 1, 1, NOM);
        cfg_write(1, 1, 0, 0, 0, 4'b0001);
        access("R11 permit via hyp bg", 2'd1, 2'd0, 32'h20000, 0, 0, NOM);
        // R8 EL2 sees only hypervisor table
        access("R8 EL2 bg", 2'd2, 2'd0, 32'h20000, 0, 0, NOM);
        access("R8 EL2 fetch ignores guest xn", 2'd2, 2'd2, 32'h4000, 0, 0, 1);
        access("R8 EL3 code as EL2", 2'd3, 2'd1, 32'h1000, 1, 0, 0);
        // R10 stage-2 refusal
        access("R10 write hyp ro", 2'd1, 2'd1, 32'h1000, 1, 1, 0);
        access("R10 EL0 read passes", 2'd0, 2'd0, 32'h1000, 0, 0, 0);
        // R12 ignored index and same-cycle write
        cfg_write(1, 1, 0, 0, 0, 4'b0000);
        cfg_write(1, 0, 24, 32'h30000, 32'h30000, 4'b1001);
        access("R12 index 24 ignored", 2'd2, 2'd0, 32'h30000, 1, 0, NOM);
        cfg_we = 1; cfg_hyp = 1; cfg_bg = 0; cfg_idx = 5'd2;
        cfg_base = 32'h30000; cfg_limit = 32'h30000; cfg_attr = 4'b1001;
        req_valid = 1; req_el = 2'd2; req_type = 2'd0; req_addr = 32'h30000;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        m_write(1, 0, 2, 32'h30000, 32'h30000, 4'b1001);
        chk("R12 same-cycle old contents", {31'd0, rsp_fault}, 1);
        access("R12 write visible next", 2'd2, 2'd0, 32'h30000, 0, 0, 2);

        // Random mix: writes alongside requests, model checked each cycle
        void'($urandom(32'h5eed));
        for (int n = 0; n < 6000; n++) begin
            bit dow, ef, es; int eidx;
            logic [31:0] a, b;
            logic [1:0] el, ty;
            dow = ($urandom % 4) == 0;
            if (dow) begin
                b = ($urandom % 256) << 6;
                cfg_we = 1; cfg_hyp = $urandom % 2; cfg_bg = ($urandom % 16) == 0;
                cfg_idx = RIDX_W'($urandom % 28);
                cfg_base = b | ($urandom % 64);
                cfg_limit = b + (($urandom % 48) << 6) + ($urandom % 64);
                cfg_attr = 4'($urandom) | 4'(($urandom % 4) != 0);
            end
            a = ($urandom % 20480);
            el = 2'($urandom); ty = 2'($urandom);
            req_valid = 1; req_el = el; req_type = ty; req_addr = a;
            m_expect(a, el, ty, ef, es, eidx);
            @(negedge clk);
            if (dow) begin
                cfg_we = 0;
                m_write(cfg_hyp, cfg_bg, int'(cfg_idx), cfg_base, cfg_limit, cfg_attr);
            end
            req_valid = 0;
            chk("R2 random valid", {31'd0, rsp_valid}, 1);
            chk(el[1] ? "R8 random result" : "R9/R10/R11 random result",
                {27'd0, rsp_region, rsp_stage2, rsp_fault}, {eidx[4:0], es, ef});
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule